// File: doc/BRIEF.md
# Power-State LED Blink Controller

This block drives a single LED pin whose appearance follows the platform power state. Three 3-bit mode fields, one for each of the states S0, S3 and S5, choose how the pin behaves while that state is current. A mode can hold the pin low, drive it high or release it under control of a drive-enable input, or make it blink at one of four frequencies with a square or narrow-pulse duty. An invert-disable bit sets the polarity of every blink mode. A deep-S3 bit replaces the S3 behaviour with a fixed slow pattern that stays high most of the time.

All timing comes from an 8 Hz enable tick. A free-running 6-bit phase counter advances once per tick and wraps every 64 ticks (8 s). Every blink waveform is decoded from this one counter, so changing the mode or the power state never restarts a pattern and all patterns stay in phase. Each system clock edge samples the power state, the fields, the polarity bit and the drive enable. The pin value and its output enable come from registers and change one clock after their inputs.

A small Moore machine holds the drive class: DRV_LOW (pin held low), DRV_LEVEL (pin high, enable from drive-enable), DRV_BLINK (pin follows the selected waveform) and DRV_DEEP (pin follows the fixed deep-S3 waveform). On every clock edge the machine moves to the class of the mode that is now selected. The transitions are: any state to DRV_DEEP when the state is S3 and deep-S3 is set; otherwise any state to DRV_LOW for mode 000, to DRV_LEVEL for mode 001, and to DRV_BLINK for modes 010 to 111. Reset forces DRV_LOW.

Top module: `pstate_led_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, the pin is low with its output enable high, and the phase counter starts from 0.
- R2: Mode 3'b000 drives the pin low with the output enable high.
- R3: Mode 3'b001 sets the pin value high and makes the output enable equal to the drive-enable input.
- R4: With invert-disable at 1, the 50%-duty modes give a pin that is high for the first half of each period, counted from phase 0: 3'b011 has an 8-tick period (1 Hz), 3'b010 16 ticks (0.5 Hz), 3'b101 32 ticks (0.25 Hz) and 3'b100 64 ticks (0.125 Hz).
- R5: Modes 3'b111 (32-tick period) and 3'b110 (64-tick period) are high for the first quarter of the period when invert-disable is 1. When it is 0 they are low for that quarter and high for the rest (75% duty).
- R6: With invert-disable at 0, every 50%-duty mode is the bitwise inverse of its R4 waveform. Modes 3'b000 and 3'b001 are never inverted.
- R7: When the power state is S3 (2'b01) and deep-S3 is 1, the pin is high except during the first 8 ticks of every 32-tick period, whatever the S3 field and invert-disable are. The output enable is high.
- R8: Deep-S3 has no effect while the power state is S0 (2'b00) or S5 (2'b10 or 2'b11).
- R9: Power-state code 2'b11 behaves exactly like S5 and uses the S5 field.
- R10: Code 2'b00 selects the S0 field, 2'b01 the S3 field and 2'b10 the S5 field. The two fields that are not selected have no effect on the pin.
- R11: The outputs reflect the inputs sampled at the previous clock edge. The phase counter advances by one per tick, wraps at 64 and is never restarted by a change of mode or power state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_8hz | input | 1 | One-cycle enable pulse at 8 Hz |
| pwr_state | input | 2 | Power state: 00 S0, 01 S3, 10 S5, 11 treated as S5 |
| s0_mode | input | 3 | Mode field used in S0 |
| s3_mode | input | 3 | Mode field used in S3 |
| s5_mode | input | 3 | Mode field used in S5 |
| inv_dis | input | 1 | 1 keeps blink waveforms as coded, 0 inverts them |
| ds3_en | input | 1 | Deep-S3 pattern enable |
| drv_en | input | 1 | Drive enable for the level mode |
| led_out | output | 1 | Pin value |
| led_oe | output | 1 | Pin output enable |

## Verification
The bench sweeps every mode in every power state under both polarities for more than one full 64-tick phase wrap. A design that decoded the wrong phase bit would show the wrong period, and one that inverted the level modes would light the LED in mode 000. Deep-S3 is also set in S0 and S5, where it must change nothing, and in S3 with several S3 fields underneath; a design that let the override leak out of S3, or let the field win, shows the wrong pattern. The bench uses code 2'b11, gives the unselected fields different values, and at the end changes mode and state every few cycles in the middle of a period. A design that restarted the phase on a change, read the wrong field, or added or dropped a register stage fails these checks.

// File: rtl/led_ctrl_pkg.sv
`timescale 1ns/1ps
package led_ctrl_pkg;

    typedef enum logic [1:0] {
        PS_S0  = 2'b00,
        PS_S3  = 2'b01,
        PS_S5  = 2'b10,
        PS_RSV = 2'b11
    } pstate_e;

    typedef enum logic [2:0] {
        MD_LOW           = 3'b000,
        MD_LEVEL         = 3'b001,
        MD_HALF_SQ       = 3'b010,
        MD_ONE_SQ        = 3'b011,
        MD_EIGHTH_SQ     = 3'b100,
        MD_QUARTER_SQ    = 3'b101,
        MD_EIGHTH_PULSE  = 3'b110,
        MD_QUARTER_PULSE = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        DRV_LOW   = 2'd0,
        DRV_LEVEL = 2'd1,
        DRV_BLINK = 2'd2,
        DRV_DEEP  = 2'd3
    } drv_state_e;

    typedef struct packed {
        mode_e mode;
        logic  deep;
    } sel_t;

endpackage

// File: rtl/led_phase_ctr.sv
`timescale 1ns/1ps
module led_phase_ctr #(
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    output logic [PHASE_W-1:0] phase_o
);

    logic [PHASE_W-1:0] phase_q;

    // free-running phase, wraps naturally at 2**PHASE_W ticks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick_i) begin
            phase_q <= phase_q + PHASE_W'(1);
        end
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/led_mode_sel.sv
`timescale 1ns/1ps
module led_mode_sel
    import led_ctrl_pkg::*;
(
    input  logic [1:0] pwr_state_i,
    input  logic [2:0] s0_mode_i,
    input  logic [2:0] s3_mode_i,
    input  logic [2:0] s5_mode_i,
    input  logic       ds3_en_i,
    output sel_t       sel_o
);

    logic [2:0] fld;

    always_comb begin
        unique case (pstate_e'(pwr_state_i))
            PS_S0:         fld = s0_mode_i;
            PS_S3:         fld = s3_mode_i;
            PS_S5, PS_RSV: fld = s5_mode_i;
            default:       fld = s5_mode_i;
        endcase
    end

    assign sel_o.mode = mode_e'(fld);
    assign sel_o.deep = ds3_en_i && (pstate_e'(pwr_state_i) == PS_S3);

endmodule

// File: rtl/led_wave_gen.sv
`timescale 1ns/1ps
module led_wave_gen
    import led_ctrl_pkg::*;
#(
    parameter int N_SQ = 4
) (
    input  logic [N_SQ-1:0] phase_hi_i,  // phase bits from the 1 Hz bit upward
    input  mode_e           mode_i,
    input  logic            inv_dis_i,
    input  logic            deep_i,
    output logic            wave_o
);

    localparam int N_PULSE = N_SQ - 2;

    logic [N_SQ-1:0]    sq;     // index 0: 1 Hz ... index 3: 0.125 Hz, 50% duty
    logic [N_PULSE-1:0] pulse;  // index 0: 0.25 Hz, index 1: 0.125 Hz, 25% duty
    logic               raw;

    generate
        for (genvar k = 0; k < N_SQ; k++) begin : g_sq
            assign sq[k] = ~phase_hi_i[k];
        end
        for (genvar k = 0; k < N_PULSE; k++) begin : g_pulse
            assign pulse[k] = (phase_hi_i[k+2 -: 2] == 2'b00);
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            MD_ONE_SQ:        raw = sq[0];
            MD_HALF_SQ:       raw = sq[1];
            MD_QUARTER_SQ:    raw = sq[2];
            MD_EIGHTH_SQ:     raw = sq[3];
            MD_QUARTER_PULSE: raw = pulse[0];
            MD_EIGHTH_PULSE:  raw = pulse[1];
            MD_LOW, MD_LEVEL: raw = 1'b0;
            default:          raw = 1'b0;
        endcase
    end

    // deep pattern is a fixed 75% waveform, polarity bit does not touch it
    assign wave_o = deep_i ? ~pulse[0] : (inv_dis_i ? raw : ~raw);

endmodule

// File: rtl/pstate_led_ctrl.sv
`timescale 1ns/1ps
module pstate_led_ctrl
    import led_ctrl_pkg::*;
#(
    parameter int TICK_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_8hz,
    input  logic [1:0] pwr_state,
    input  logic [2:0] s0_mode,
    input  logic [2:0] s3_mode,
    input  logic [2:0] s5_mode,
    input  logic       inv_dis,
    input  logic       ds3_en,
    input  logic       drv_en,
    output logic       led_out,
    output logic       led_oe
);

    localparam int PHASE_W = TICK_LOG2 + 3;  // 8 s of ticks
    localparam int N_SQ    = 4;              // 1, 0.5, 0.25, 0.125 Hz

    logic [PHASE_W-1:0] phase_w;
    sel_t               sel;
    logic               wave_d;
    drv_state_e         state_q, state_d;
    logic               wave_q;
    logic               lvl_q;

    led_phase_ctr #(.PHASE_W(PHASE_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_8hz),
        .phase_o (phase_w)
    );

    led_mode_sel u_sel (
        .pwr_state_i (pwr_state),
        .s0_mode_i   (s0_mode),
        .s3_mode_i   (s3_mode),
        .s5_mode_i   (s5_mode),
        .ds3_en_i    (ds3_en),
        .sel_o       (sel)
    );

    led_wave_gen #(.N_SQ(N_SQ)) u_wave (
        .phase_hi_i (phase_w[PHASE_W-1 -: N_SQ]),
        .mode_i     (sel.mode),
        .inv_dis_i  (inv_dis),
        .deep_i     (sel.deep),
        .wave_o     (wave_d)
    );

    // next drive class
    always_comb begin
        if (sel.deep) begin
            state_d = DRV_DEEP;
        end else begin
            unique case (sel.mode)
                MD_LOW:   state_d = DRV_LOW;
                MD_LEVEL: state_d = DRV_LEVEL;
                default:  state_d = DRV_BLINK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DRV_LOW;
            wave_q  <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            wave_q  <= wave_d;
            lvl_q   <= drv_en;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DRV_LOW: begin
                led_out = 1'b0;
                led_oe  = 1'b1;
            end
            DRV_LEVEL: begin
                led_out = 1'b1;
                led_oe  = lvl_q;
            end
            DRV_BLINK, DRV_DEEP: begin
                led_out = wave_q;
                led_oe  = 1'b1;
            end
            default: begin
                led_out = 1'b0;
                led_oe  = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/led_ctrl_chk.sv
`timescale 1ns/1ps
module led_ctrl_chk #(
    parameter int TICK_LOG2 = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_8hz,
    input logic [1:0]             pwr_state,
    input logic [2:0]             s0_mode,
    input logic [2:0]             s3_mode,
    input logic [2:0]             s5_mode,
    input logic                   inv_dis,
    input logic                   ds3_en,
    input logic                   drv_en,
    input logic                   led_out,
    input logic                   led_oe,
    input logic [TICK_LOG2+2:0]   phase
);

    localparam int PW = TICK_LOG2 + 3;

    logic [2:0] cur_fld;
    logic       deep_act;

    assign cur_fld  = (pwr_state == 2'b00) ? s0_mode :
                      (pwr_state == 2'b01) ? s3_mode : s5_mode;
    assign deep_act = ds3_en && (pwr_state == 2'b01);

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_8hz |=> phase == PW'($past(phase) + PW'(1)));  // R11

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_8hz |=> $stable(phase));  // R11

    AST_LOW_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep_act && cur_fld == 3'b000) |=> (!led_out && led_oe));  // R2

    AST_LEVEL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep_act && cur_fld == 3'b001) |=> (led_out && (led_oe == $past(drv_en))));  // R3

    AST_BLINK_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (deep_act || cur_fld[2:1] != 2'b00) |=> led_oe);  // R4

    AST_DEEP_WAVE: assert property (@(posedge clk) disable iff (!rst_n)
        deep_act |=> (led_out == ($past(phase[TICK_LOG2+1:TICK_LOG2]) != 2'b00)));  // R7

    AST_PULSE_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!deep_act && cur_fld == 3'b111 && !inv_dis)
            |=> (led_out == ($past(phase[TICK_LOG2+1:TICK_LOG2]) != 2'b00)));  // R5

    always_comb begin
        if (!rst_n) begin
            AST_RESET_STATE: assert (phase == '0);  // R1
        end
    end

endmodule

bind pstate_led_ctrl led_ctrl_chk #(.TICK_LOG2(TICK_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_8hz  (tick_8hz),
    .pwr_state (pwr_state),
    .s0_mode   (s0_mode),
    .s3_mode   (s3_mode),
    .s5_mode   (s5_mode),
    .inv_dis   (inv_dis),
    .ds3_en    (ds3_en),
    .drv_en    (drv_en),
    .led_out   (led_out),
    .led_oe    (led_oe),
    .phase     (phase_w)
);

// File: tb/sim_pstate_led_ctrl.sv
`timescale 1ns/1ps
module sim_pstate_led_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_8hz = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic [2:0] s0_mode = 3'd0, s3_mode = 3'd0, s5_mode = 3'd0;
    logic       inv_dis = 1'b0, ds3_en = 1'b0, drv_en = 1'b0;
    logic       led_out, led_oe;

    always #2.5 clk = ~clk;  // 200 MHz

    pstate_led_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_8hz(tick_8hz), .pwr_state(pwr_state),
        .s0_mode(s0_mode), .s3_mode(s3_mode), .s5_mode(s5_mode),
        .inv_dis(inv_dis), .ds3_en(ds3_en), .drv_en(drv_en),
        .led_out(led_out), .led_oe(led_oe)
    );

    int    checks = 0;
    int    errors = 0;
    int    ph = 0;
    int    cyc = 0;
    int    wd = 0;
    logic  exp_out = 1'b0, exp_oe = 1'b1, exp_valid = 1'b0;
    string sect = "R1";
    string tag = "R1";

    // nominal blink waveforms in ticks, before polarity
    function automatic logic blink(int m, int p);
        case (m)
            2: return (p % 16) < 8;
            3: return (p % 8) < 4;
            4: return (p % 64) < 32;
            5: return (p % 32) < 16;
            6: return (p % 64) < 16;
            default: return (p % 32) < 8;
        endcase
    endfunction

    // reference model: result of each edge, phase updated after use
    always @(posedge clk) begin
        int f;
        if (!rst_n) begin
            ph = 0; exp_out = 1'b0; exp_oe = 1'b1; tag = "R1";
        end else begin
            f = (pwr_state == 2'b00) ? int'(s0_mode) :
                (pwr_state == 2'b01) ? int'(s3_mode) : int'(s5_mode);
            if (pwr_state == 2'b01 && ds3_en) begin
                exp_out = !((ph % 32) < 8); exp_oe = 1'b1; tag = "R7";
            end else if (f == 0) begin
                exp_out = 1'b0; exp_oe = 1'b1; tag = "R2";
            end else if (f == 1) begin
                exp_out = 1'b1; exp_oe = drv_en; tag = "R3";
            end else begin
                exp_out = inv_dis ? blink(f, ph) : !blink(f, ph);
                exp_oe  = 1'b1;
                tag = (f >= 6) ? "R5" : (inv_dis ? "R4" : "R6");
            end
            if (tick_8hz) ph = (ph + 1) % 64;
        end
        exp_valid = 1'b1;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (exp_valid) begin
            checks++;
            if (led_out !== exp_out || led_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s/%s t=%0t: out=%b oe=%b expected out=%b oe=%b",
                         sect, tag, $time, led_out, led_oe, exp_out, exp_oe);
            end
        end
    end

    // tick every 4 clocks, drive-enable pattern
    always @(negedge clk) begin
        cyc++;
        tick_8hz <= rst_n && (cyc % 4 == 0);
        drv_en   <= logic'(((cyc / 4) % 2) ^ ((cyc / 32) % 2));
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog R11: actual run still going, expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_field(int ps, int m);
        int other;
        other = (m + 3) % 8;
        s0_mode = 3'(other); s3_mode = 3'(other); s5_mode = 3'(other);
        case (ps)
            0: s0_mode = 3'(m);
            1: s3_mode = 3'(m);
            default: s5_mode = 3'(m);
        endcase
        pwr_state = 2'(ps);
    endtask

    initial begin
        // R1: reset state
        sect = "R1";
        run(4);
        rst_n = 1'b1;
        run(4);

        // R10: per-state field selection, all modes, both polarities
        sect = "R10";
        for (int ps = 0; ps < 3; ps++) begin
            for (int iv = 0; iv < 2; iv++) begin
                for (int m = 0; m < 8; m++) begin
                    inv_dis = logic'(iv);
                    set_field(ps, m);
                    run(280);
                end
            end
        end

        // R9: code 2'b11 uses the S5 field
        sect = "R9";
        for (int m = 0; m < 8; m++) begin
            inv_dis = logic'(m % 2);
            set_field(3, m);
            run(280);
        end

        // R7: deep-S3 overrides the S3 field and polarity
        sect = "R7";
        ds3_en = 1'b1;
        for (int m = 0; m < 8; m += 3) begin
            inv_dis = logic'(m % 2);
            set_field(1, m);
            run(300);
        end

        // R8: deep-S3 ignored outside S3
        sect = "R8";
        for (int ps = 0; ps < 4; ps++) begin
            if (ps != 1) begin
                inv_dis = 1'b0;
                set_field(ps, 7);
                run(300);
                set_field(ps, 0);
                run(40);
            end
        end
        ds3_en = 1'b0;

        // R11: changes mid-period, phase never restarted
        sect = "R11";
        for (int i = 0; i < 120; i++) begin
            set_field(i % 4, (i * 5) % 8);
            inv_dis = logic'((i / 3) % 2);
            ds3_en  = logic'(i % 3 == 0);
            run(7);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule